// File: doc/BRIEF.md
# Per-Field Sample Statistics Accumulator

This block sits beside a delay stage that carries a field of pixel or transform-coefficient samples. As the samples of one field stream past, it gathers four figures over that field in a single pass: the smallest sample, the largest sample, the sum of all samples and the sum of their squares. It also keeps a count of the samples it took. Because it works on the field that is currently entering the delay stage, the results describe the same field that a rate-control step will quantize next. That step derives its quantizer bin widths from these figures while the field is still held in the delay memory.

A field is framed by a start marker and an end marker. The sample presented with either marker belongs to the field. At the end marker, all results are captured into output registers and a one-cycle done strobe is raised. The captured values stay put until the next field closes. A field that closes without any valid sample reports a zero count, and a flag marks its minimum and maximum as meaningless.

Top module: `fieldStatsAcc`

## Requirements
- R1: While reset is held and after it is released, before any field has closed, resDone and resRangeValid are 0 and every result output is 0.
- R2: resMin and resMax are the smallest and largest valid samples of the field, with samples read as 16-bit two's complement.
- R3: resSum is the signed sum of the field's valid samples, in 36-bit two's complement.
- R4: resSumSq is the unsigned 52-bit sum of the squares of the field's valid samples.
- R5: resCount is the number of valid samples in the field. The sample on the fieldStart cycle counts if inValid is high, and so does the sample on the fieldEnd cycle.
- R6: resDone is high for exactly one cycle. It is raised in the cycle after the clock edge that samples fieldEnd within an open field. All results change in that same cycle.
- R7: When resDone is low, every result output holds its value.
- R8: A field with no valid samples reports resCount 0, resSum 0, resSumSq 0 and resRangeValid 0. In that case resMin is 32767 and resMax is -32768. resRangeValid is 1 for any field with at least one sample.
- R9: When no field is open, inValid samples and fieldEnd are ignored. They raise no resDone and leave the results unchanged.
- R10: A fieldStart inside an open field discards everything gathered so far without raising resDone. The field then continues from that start.
- R11: Cycles with inValid low inside a field contribute nothing, whatever value is on inSample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | inSample carries a sample this cycle |
| inSample | input | 16 | Signed sample |
| fieldStart | input | 1 | First cycle of a field |
| fieldEnd | input | 1 | Last cycle of a field |
| resMin | output | 16 | Smallest sample of the last closed field |
| resMax | output | 16 | Largest sample of the last closed field |
| resSum | output | 36 | Signed sum of the last closed field |
| resSumSq | output | 52 | Sum of squares of the last closed field |
| resCount | output | 20 | Sample count of the last closed field |
| resRangeValid | output | 1 | resMin/resMax are meaningful |
| resDone | output | 1 | One-cycle strobe: new results present |

## Verification
Every result has a latency of one cycle. It is registered at the rising edge that samples fieldEnd, so it is visible, with resDone, during the following cycle. The bench changes its inputs on falling edges. It reads the results at the falling edge right after the closing rising edge, and once more a cycle later to confirm that resDone has dropped and the values are held. Expected figures come from running arithmetic in the bench. One field sweeps every 16-bit value.

// File: rtl/fieldStatsPkg.sv
package fieldStatsPkg;

  // Strobes from the control to the datapath, valid in the current cycle
  typedef struct packed {
    logic clearAcc;    // restart accumulation from the initial values
    logic takeSample;  // fold inSample into the running statistics
    logic latchOut;    // copy the updated statistics into the result registers
  } statsCtrl_t;

endpackage

// File: rtl/fieldStatsCtrl.sv
module fieldStatsCtrl
  import fieldStatsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       fieldStart,
  input  logic       fieldEnd,
  output statsCtrl_t ctrl,
  output logic       doneOut
);

  logic inField;
  logic openNow;

  // A field is open this cycle if it was already open or starts here
  assign openNow = inField | fieldStart;

  always_comb begin
    ctrl.clearAcc   = fieldStart;
    ctrl.takeSample = inValid & openNow;
    ctrl.latchOut   = fieldEnd & openNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inField <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= ctrl.latchOut;
      if (ctrl.latchOut)  inField <= 1'b0;
      else if (fieldStart) inField <= 1'b1;
    end
  end

endmodule

// File: rtl/fieldStatsExtreme.sv
module fieldStatsExtreme #(
  parameter int SAMPLE_W = 16,
  parameter bit FIND_MAX = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clearAcc,
  input  logic                       takeSample,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic signed [SAMPLE_W-1:0] nextVal
);

  localparam logic signed [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic signed [SAMPLE_W-1:0] initVal;
  logic signed [SAMPLE_W-1:0] accVal;
  logic signed [SAMPLE_W-1:0] baseVal;
  logic                       replace;

  generate
    if (FIND_MAX) begin : g_max
      assign initVal = MOST_NEG;
      assign replace = sample > baseVal;
    end else begin : g_min
      assign initVal = MOST_POS;
      assign replace = sample < baseVal;
    end
  endgenerate

  always_comb begin
    baseVal = clearAcc ? initVal : accVal;
    nextVal = (takeSample && replace) ? sample : baseVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) accVal <= initVal;
    else       accVal <= nextVal;
  end

endmodule

// File: rtl/fieldStatsPath.sv
module fieldStatsPath
  import fieldStatsPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = 36,
  parameter int SQ_W     = 52,
  parameter int CNT_W    = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  statsCtrl_t          ctrl,
  input  logic [SAMPLE_W-1:0] inSample,
  output logic [SAMPLE_W-1:0] resMin,
  output logic [SAMPLE_W-1:0] resMax,
  output logic [SUM_W-1:0]    resSum,
  output logic [SQ_W-1:0]     resSumSq,
  output logic [CNT_W-1:0]    resCount,
  output logic                resRangeValid
);

  localparam int PROD_W = 2 * SAMPLE_W;

  logic signed [SAMPLE_W-1:0] sampleS;
  logic signed [SAMPLE_W-1:0] nextMin, nextMax;
  logic signed [PROD_W-1:0]   square;
  logic [SUM_W-1:0]  sampleExt;
  logic [SQ_W-1:0]   squareExt;
  logic [SUM_W-1:0]  accSum, baseSum, nextSum;
  logic [SQ_W-1:0]   accSq, baseSq, nextSq;
  logic [CNT_W-1:0]  accCnt, baseCnt, nextCnt;

  assign sampleS = $signed(inSample);
  assign square  = sampleS * sampleS;   // never negative
  assign sampleExt = {{(SUM_W-SAMPLE_W){sampleS[SAMPLE_W-1]}}, sampleS};
  assign squareExt = {{(SQ_W-PROD_W){1'b0}}, square};

  fieldStatsExtreme #(.SAMPLE_W(SAMPLE_W), .FIND_MAX(1'b0)) u_min (
    .clk(clk), .rstN(rstN), .clearAcc(ctrl.clearAcc),
    .takeSample(ctrl.takeSample), .sample(sampleS), .nextVal(nextMin)
  );

  fieldStatsExtreme #(.SAMPLE_W(SAMPLE_W), .FIND_MAX(1'b1)) u_max (
    .clk(clk), .rstN(rstN), .clearAcc(ctrl.clearAcc),
    .takeSample(ctrl.takeSample), .sample(sampleS), .nextVal(nextMax)
  );

  always_comb begin
    baseSum = ctrl.clearAcc ? '0 : accSum;
    baseSq  = ctrl.clearAcc ? '0 : accSq;
    baseCnt = ctrl.clearAcc ? '0 : accCnt;
    nextSum = ctrl.takeSample ? baseSum + sampleExt     : baseSum;
    nextSq  = ctrl.takeSample ? baseSq + squareExt      : baseSq;
    nextCnt = ctrl.takeSample ? baseCnt + CNT_W'(1)     : baseCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSum <= '0;
      accSq  <= '0;
      accCnt <= '0;
    end else begin
      accSum <= nextSum;
      accSq  <= nextSq;
      accCnt <= nextCnt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resMin        <= '0;
      resMax        <= '0;
      resSum        <= '0;
      resSumSq      <= '0;
      resCount      <= '0;
      resRangeValid <= 1'b0;
    end else if (ctrl.latchOut) begin
      resMin        <= nextMin;
      resMax        <= nextMax;
      resSum        <= nextSum;
      resSumSq      <= nextSq;
      resCount      <= nextCnt;
      resRangeValid <= (nextCnt != '0);
    end
  end

endmodule

// File: rtl/fieldStatsAcc.sv
module fieldStatsAcc
  import fieldStatsPkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = 36,
  parameter int SQ_W     = 52,
  parameter int CNT_W    = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inSample,
  input  logic                fieldStart,
  input  logic                fieldEnd,
  output logic [SAMPLE_W-1:0] resMin,
  output logic [SAMPLE_W-1:0] resMax,
  output logic [SUM_W-1:0]    resSum,
  output logic [SQ_W-1:0]     resSumSq,
  output logic [CNT_W-1:0]    resCount,
  output logic                resRangeValid,
  output logic                resDone
);

  statsCtrl_t ctrl;

  fieldStatsCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .fieldStart(fieldStart), .fieldEnd(fieldEnd),
    .ctrl(ctrl), .doneOut(resDone)
  );

  fieldStatsPath #(
    .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .CNT_W(CNT_W)
  ) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inSample(inSample),
    .resMin(resMin), .resMax(resMax), .resSum(resSum),
    .resSumSq(resSumSq), .resCount(resCount), .resRangeValid(resRangeValid)
  );

endmodule

// File: rtl/fieldStatsChk.sv
module fieldStatsChk #(
  parameter int SAMPLE_W = 16,
  parameter int SUM_W    = 36,
  parameter int SQ_W     = 52,
  parameter int CNT_W    = 20
) (
  input logic                clk,
  input logic                rstN,
  input logic                fieldEnd,
  input logic [SAMPLE_W-1:0] resMin,
  input logic [SAMPLE_W-1:0] resMax,
  input logic [SUM_W-1:0]    resSum,
  input logic [SQ_W-1:0]     resSumSq,
  input logic [CNT_W-1:0]    resCount,
  input logic                resRangeValid,
  input logic                resDone
);

  // R6: a done strobe always follows a sampled field end
  p_done_after_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    resDone |-> $past(fieldEnd));

  // R7: results only move together with the done strobe
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !resDone |-> ($stable(resMin) && $stable(resMax) && $stable(resSum) &&
                  $stable(resSumSq) && $stable(resCount) && $stable(resRangeValid)));

  // R2: a valid range is ordered
  p_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    resRangeValid |-> ($signed(resMin) <= $signed(resMax)));

  // R8: an empty or not-yet-closed field reports zero sums and count
  p_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    !resRangeValid |-> (resCount == '0 && resSum == '0 && resSumSq == '0));

  // R5: a single-sample field has equal extremes
  p_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resRangeValid && resCount == CNT_W'(1)) |-> (resMin == resMax));

  // R4: a zero sum of squares means every sample was zero
  p_sq_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (resRangeValid && resSumSq == '0) |-> (resMin == '0 && resMax == '0));

endmodule

bind fieldStatsAcc fieldStatsChk #(
  .SAMPLE_W(SAMPLE_W), .SUM_W(SUM_W), .SQ_W(SQ_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .fieldEnd(fieldEnd),
  .resMin(resMin), .resMax(resMax), .resSum(resSum), .resSumSq(resSumSq),
  .resCount(resCount), .resRangeValid(resRangeValid), .resDone(resDone)
);

// File: tb/fieldStatsAcc_tb.sv
module fieldStatsAcc_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inSample = '0;
  logic        fieldStart = 1'b0;
  logic        fieldEnd = 1'b0;
  logic [15:0] resMin, resMax;
  logic [35:0] resSum;
  logic [51:0] resSumSq;
  logic [19:0] resCount;
  logic        resRangeValid, resDone;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  int     expMin, expMax, expCnt;
  longint expSum, expSq;

  always #10 clk = ~clk;  // 50 MHz

  fieldStatsAcc u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .fieldStart(fieldStart), .fieldEnd(fieldEnd),
    .resMin(resMin), .resMax(resMax), .resSum(resSum), .resSumSq(resSumSq),
    .resCount(resCount), .resRangeValid(resRangeValid), .resDone(resDone)
  );

  task automatic chk(string req, string what, longint got, longint exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int sampleOf(int i, int seed);
    if (seed < 0)  return i - 32768;
    if (seed == 3) return -32768;
    if (seed == 4) return 32767;
    return ((i * 7919 + seed * 104729) % 65536) - 32768;
  endfunction

  task automatic modelClear();
    expMin = 32767; expMax = -32768; expCnt = 0; expSum = 0; expSq = 0;
  endtask

  task automatic modelAdd(int s);
    if (s < expMin) expMin = s;
    if (s > expMax) expMax = s;
    expSum += s;
    expSq  += longint'(s) * longint'(s);
    expCnt++;
  endtask

  task automatic idle();
    inValid = 1'b0; fieldStart = 1'b0; fieldEnd = 1'b0; inSample = 16'hA5A5;
  endtask

  task automatic checkHeld(string req);
    longint gMin, gMax, gSum;
    gMin = longint'($signed(resMin));
    gMax = longint'($signed(resMax));
    gSum = longint'($signed(resSum));
    chk(req, "min", gMin, expMin);
    chk(req, "max", gMax, expMax);
    chk(req, "sum", gSum, expSum);
    chk(req, "sumSq", longint'(resSumSq), expSq);
    chk(req, "count", longint'(resCount), expCnt);
    chk(req, "rangeValid", longint'(resRangeValid), longint'(expCnt != 0));
  endtask

  // Called at the negedge after the closing edge
  task automatic checkResults(string tag);
    chk({"R6 ", tag}, "done", longint'(resDone), 1);
    chk({"R2 ", tag}, "min", longint'($signed(resMin)), expMin);
    chk({"R2 ", tag}, "max", longint'($signed(resMax)), expMax);
    chk({"R3 ", tag}, "sum", longint'($signed(resSum)), expSum);
    chk({"R4 ", tag}, "sumSq", longint'(resSumSq), expSq);
    chk({"R5 ", tag}, "count", longint'(resCount), expCnt);
    chk({"R8 ", tag}, "rangeValid", longint'(resRangeValid), longint'(expCnt != 0));
    @(negedge clk);
    chk({"R6 ", tag}, "done drop", longint'(resDone), 0);
    checkHeld({"R7 ", tag});
  endtask

  task automatic runField(int len, int seed, bit gaps, string tag);
    int i = 0;
    int k = 0;
    modelClear();
    while (k < len) begin
      bit v;
      int s;
      @(negedge clk);
      v = !(gaps && (i % 3 == 2));
      s = sampleOf(i, seed);
      inSample   = 16'(s);
      inValid    = v;
      fieldStart = (i == 0);
      fieldEnd   = v && (k == len - 1);
      if (v) begin
        modelAdd(s);
        k++;
      end
      i++;
    end
    @(negedge clk);
    idle();
    checkResults(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", longint'(resDone), 0);
    chk("R1", "count in reset", longint'(resCount), 0);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1", "done", longint'(resDone), 0);
    chk("R1", "rangeValid", longint'(resRangeValid), 0);
    chk("R1", "min", longint'(resMin), 0);
    chk("R1", "max", longint'(resMax), 0);
    chk("R1", "sum", longint'(resSum), 0);
    chk("R1", "sumSq", longint'(resSumSq), 0);

    // Single sample: start and end in the same cycle (R5, R6)
    runField(1, 7, 1'b0, "single");
    runField(2, 9, 1'b0, "pair");
    runField(17, 11, 1'b0, "short");
    runField(300, 3, 1'b0, "allMostNeg");
    runField(300, 4, 1'b0, "allMostPos");
    runField(513, 21, 1'b0, "mixed");
    // Gaps carrying junk samples (R11)
    runField(200, 33, 1'b1, "R11 gaps");

    // Empty field, start then end (R8)
    @(negedge clk); modelClear(); fieldStart = 1'b1;
    @(negedge clk); fieldStart = 1'b0; fieldEnd = 1'b1;
    @(negedge clk); idle();
    checkResults("R8 empty");
    // Empty field, start and end together (R8)
    @(negedge clk); fieldStart = 1'b1; fieldEnd = 1'b1;
    @(negedge clk); idle();
    checkResults("R8 emptySame");

    // Outside a field: samples and a stray end are ignored (R9)
    runField(5, 13, 1'b0, "pre R9");
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk("R9", "done outside", longint'(resDone), 0);
      inValid = 1'b1; inSample = 16'(32767 - j); fieldEnd = (j == 5);
    end
    @(negedge clk); idle();
    chk("R9", "done after stray end", longint'(resDone), 0);
    @(negedge clk);
    chk("R9", "done", longint'(resDone), 0);
    checkHeld("R9");

    // Restart inside an open field (R10)
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      inValid = 1'b1; inSample = 16'(-30000); fieldStart = (j == 0); fieldEnd = 1'b0;
    end
    @(negedge clk); idle();
    chk("R10", "done before restart", longint'(resDone), 0);
    runField(8, 5, 1'b0, "R10 restart");

    // Exhaustive sweep of every sample value in one field (R2 R3 R4 R5)
    runField(65536, -1, 1'b0, "sweep");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule